// File: doc/BRIEF.md
# UART Modem Control, Modem Status and Divisor Latch Registers

This block holds the modem-control side of a 16550-style serial port register file: the modem control register, the modem status register with its sticky change-detect bits, the line control register (needed for its divisor-latch select bit), the two divisor latch bytes and the scratch byte. A host reaches all of them through one byte-wide register port with a 3-bit offset, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe.

The physical modem inputs are not connected. With loopback off, the status lines read as inactive. With the loopback bit set, the four control outputs drive the four status lines inside the block. Each change on a status line is latched into a delta bit. The four delta bits are also exported on their own port, so an interrupt unit can use them. A read of the status register returns the delta bits and then clears them.

Top module: `mdm_uart_regs`

## Requirements
- R1: The modem control register sits at offset 4. A write keeps bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback). A read returns bits 7:5 as zero.
- R2: The modem status register sits at offset 6. When loopback is set, its status bits are bit 4 CTS = RTS, bit 5 DSR = DTR, bit 6 RI = OUT1 and bit 7 DCD = OUT2.
- R3: When loopback is clear, status bits 7:4 read as 0.
- R4: A control write that changes CTS, DSR or DCD, in either direction, sets delta bit 0, 1 or 3 respectively.
- R5: Delta bit 2 (ring) is set only when RI goes from 1 to 0. A rising RI leaves it unchanged.
- R6: Delta bits stay set through later control writes. A status read returns them in bits 3:0 and then clears them. The port `delta_o` always shows the current delta bits.
- R7: Host writes to offset 6 (modem status) and offset 5 (line status) change no register.
- R8: The line control register sits at offset 3 and is read/write; bit 7 is the divisor-latch select. While bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. While it is clear, writes to offsets 0 and 1 leave the divisor unchanged.
- R9: After reset, the divisor is 1,843,200 / 9600 / 16 = 12 (low byte 12, high byte 0). The control, status, delta, line control and scratch registers are all 0 after reset.
- R10: A read returns 0xFF for offset 2, offset 5, and offsets 0 and 1 while divisor-latch select is clear.
- R11: The scratch register at offset 7 stores any byte and returns it on a read.
- R12: `rdata` is updated in the cycle after `rd_en` and holds its value when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| delta_o | output | 4 | Sticky change-detect bits (CTS, DSR, ring, DCD) |

## Verification
A write takes effect at the clock edge where it is sampled, so the bench checks the new register value with a read issued in the next cycle. The results of a read are due one edge after the read strobe: the returned byte appears on `rdata` and, for a status read, the delta bits are cleared on `delta_o` at that same edge. The bench drives each operation on a falling edge and compares `rdata` and `delta_o` on the falling edge after the operation's rising edge. Its model is updated in the same order, so every comparison falls in the cycle where the result is due.

// File: rtl/mdm_uart_pkg.sv
package mdm_uart_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int NUM_LINES = 4;

  localparam logic [ADDR_W-1:0] OFS_DIV_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIV_HI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LINE   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCTL   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTAT  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTAT  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCRATCH = 3'd7;

  localparam int LINE_SEL_BIT = 7;
  localparam logic [DATA_W-1:0] UNMAPPED_VAL = 8'hFF;

  typedef struct packed {
    logic loop;
    logic aux2;
    logic aux1;
    logic rts;
    logic dtr;
  } mctl_t;
endpackage

// File: rtl/mdm_divisor_latch.sv
module mdm_divisor_latch #(
  parameter int DATA_W = 8,
  parameter int REF_HZ = 1843200,
  parameter int BAUD = 9600,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] div_q
);
  localparam int DIV_INIT = REF_HZ / BAUD / OVERSAMPLE;
  localparam logic [2*DATA_W-1:0] DIV_RST = (2*DATA_W)'(DIV_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_RST;
    end else begin
      if (wr_lo) div_q[DATA_W-1:0] <= wdata;
      if (wr_hi) div_q[2*DATA_W-1:DATA_W] <= wdata;
    end
  end

  // R8: the divisor moves only after a latch write strobe
  a_r8_div_write_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_lo) && !$past(wr_hi)) |-> $stable(div_q));
endmodule

// File: rtl/mdm_modem_ctl.sv
module mdm_modem_ctl
  import mdm_uart_pkg::*;
#(
  parameter int LINES = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mctl_wr,
  input  logic [4:0]       mctl_wdata,
  input  logic             mstat_rd,
  output mctl_t            mctl_q,
  output logic [LINES-1:0] stat_q,
  output logic [LINES-1:0] delta_q
);
  // Per-line bit positions: 0 CTS, 1 DSR, 2 RI, 3 DCD
  localparam int RI_IDX = 2;

  mctl_t            mctl_new;
  logic [LINES-1:0] stat_new;
  logic [LINES-1:0] change;
  logic [LINES-1:0] delta_keep;

  always_comb begin
    mctl_new = mctl_t'(mctl_wdata);
    if (mctl_new.loop) stat_new = {mctl_new.aux2, mctl_new.aux1, mctl_new.dtr, mctl_new.rts};
    else               stat_new = '0;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == RI_IDX) begin : g_trailing
      assign change[i] = mctl_wr & stat_q[i] & ~stat_new[i];
    end else begin : g_any
      assign change[i] = mctl_wr & (stat_q[i] ^ stat_new[i]);
    end
  end

  assign delta_keep = mstat_rd ? '0 : delta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mctl_q  <= '0;
      stat_q  <= '0;
      delta_q <= '0;
    end else begin
      if (mctl_wr) begin
        mctl_q <= mctl_new;
        stat_q <= stat_new;
      end
      delta_q <= delta_keep | change;
    end
  end

  // R2: in loopback the status lines follow the control outputs
  a_r2_loop_map: assert property (@(posedge clk) disable iff (rst)
    mctl_q.loop |-> stat_q == {mctl_q.aux2, mctl_q.aux1, mctl_q.dtr, mctl_q.rts});
  // R3: with loopback clear the status lines are inactive
  a_r3_lines_idle: assert property (@(posedge clk) disable iff (rst)
    !mctl_q.loop |-> stat_q == '0);
  // R5: ring delta rises only after RI fell
  a_r5_ring_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(delta_q[RI_IDX]) |-> ($past(stat_q[RI_IDX]) && !stat_q[RI_IDX]));
  // R6: a delta bit clears only after a status read
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (|($past(delta_q) & ~delta_q)) |-> $past(mstat_rd));
  // R7: status lines move only on a control write
  a_r7_stat_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(mctl_wr) |-> $stable(stat_q));
endmodule

// File: rtl/mdm_uart_regs.sv
module mdm_uart_regs
  import mdm_uart_pkg::*;
#(
  parameter int REF_HZ = 1843200,
  parameter int BAUD = 9600,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_LINES-1:0] delta_o
);
  logic [DATA_W-1:0]    line_q;
  logic [DATA_W-1:0]    scratch_q;
  logic [2*DATA_W-1:0]  div_q;
  mctl_t                mctl_q;
  logic [NUM_LINES-1:0] stat_q;
  logic [NUM_LINES-1:0] delta_q;
  logic                 dsel;
  logic [DATA_W-1:0]    rd_mux;

  assign dsel = line_q[LINE_SEL_BIT];

  mdm_divisor_latch #(
    .DATA_W(DATA_W), .REF_HZ(REF_HZ), .BAUD(BAUD), .OVERSAMPLE(OVERSAMPLE)
  ) u_div (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && dsel && addr == OFS_DIV_LO),
    .wr_hi(wr_en && dsel && addr == OFS_DIV_HI),
    .wdata(wdata), .div_q(div_q)
  );

  mdm_modem_ctl #(.LINES(NUM_LINES)) u_mdm (
    .clk(clk), .rst(rst),
    .mctl_wr(wr_en && addr == OFS_MCTL),
    .mctl_wdata(wdata[4:0]),
    .mstat_rd(rd_en && addr == OFS_MSTAT),
    .mctl_q(mctl_q), .stat_q(stat_q), .delta_q(delta_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= '0;
      scratch_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_LINE)    line_q    <= wdata;
      if (addr == OFS_SCRATCH) scratch_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = UNMAPPED_VAL;
    unique case (addr)
      OFS_DIV_LO:  if (dsel) rd_mux = div_q[DATA_W-1:0];
      OFS_DIV_HI:  if (dsel) rd_mux = div_q[2*DATA_W-1:DATA_W];
      OFS_LINE:    rd_mux = line_q;
      OFS_MCTL:    rd_mux = {3'b000, mctl_q};
      OFS_MSTAT:   rd_mux = {stat_q, delta_q};
      OFS_SCRATCH: rd_mux = scratch_q;
      default:     rd_mux = UNMAPPED_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign delta_o = delta_q;

  // R1: control readback never shows bits 7:5
  a_r1_mctl_upper: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == OFS_MCTL) |-> rdata[7:5] == 3'b000);
  // R12: read data holds without a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
  // R11: scratch changes only on its own write
  a_r11_scratch_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr == OFS_SCRATCH) |-> $stable(scratch_q));
endmodule

// File: tb/sim_mdm_uart_regs.sv
module sim_mdm_uart_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] delta_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [4:0] m_ctl;
  logic [3:0] m_st, m_dl;
  logic [7:0] m_line, m_scr, m_lo, m_hi;

  always #2.5 clk = ~clk;

  mdm_uart_regs u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .delta_o(delta_o));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [2:0] a);
    logic dsel = m_line[7];
    case (a)
      3'd0: return dsel ? m_lo : 8'hFF;
      3'd1: return dsel ? m_hi : 8'hFF;
      3'd3: return m_line;
      3'd4: return {3'b000, m_ctl};
      3'd6: return {m_st, m_dl};
      3'd7: return m_scr;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R8/R10";
      3'd3: return "R8";
      3'd4: return "R1";
      3'd6: return "R2/R3/R4/R5/R6";
      3'd7: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic model_write(logic [2:0] a, logic [7:0] d);
    logic [3:0] ns;
    if (m_line[7] && a == 3'd0) m_lo = d;
    else if (m_line[7] && a == 3'd1) m_hi = d;
    else case (a)
      3'd3: m_line = d;
      3'd7: m_scr = d;
      3'd4: begin
        m_ctl = d[4:0];
        ns = d[4] ? {d[3], d[2], d[0], d[1]} : 4'b0000;
        m_dl[0] = m_dl[0] | (ns[0] ^ m_st[0]);
        m_dl[1] = m_dl[1] | (ns[1] ^ m_st[1]);
        m_dl[2] = m_dl[2] | (m_st[2] & ~ns[2]);
        m_dl[3] = m_dl[3] | (ns[3] ^ m_st[3]);
        m_st = ns;
      end
      default: ;
    endcase
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check("R6 delta_o", {4'h0, delta_o}, {4'h0, m_dl});
  endtask

  task automatic rd(logic [2:0] a, string req);
    logic [7:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
    if (a == 3'd6) m_dl = '0;
    check("R6 delta_o", {4'h0, delta_o}, {4'h0, m_dl});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    m_ctl = 0; m_st = 0; m_dl = 0; m_line = 0; m_scr = 0; m_lo = 8'd12; m_hi = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 rdata", rdata, 8'h00);
    check("R9 delta", {4'h0, delta_o}, 8'h00);
    rd(3'd4, "R9 ctl");
    rd(3'd6, "R9 status");
    rd(3'd7, "R9 scratch");
    wr(3'd3, 8'h80);
    rd(3'd0, "R9 div lo=12");
    rd(3'd1, "R9 div hi=0");
    wr(3'd3, 8'h03);
    // R10 unmapped and R8 gated offsets
    rd(3'd0, "R10 ofs0");
    rd(3'd2, "R10 ofs2");
    rd(3'd5, "R10 ofs5");
    wr(3'd0, 8'h55);
    wr(3'd3, 8'h83);
    rd(3'd0, "R8 div lo untouched");
    wr(3'd1, 8'hA5);
    rd(3'd1, "R8 div hi written");
    wr(3'd3, 8'h03);
    // R1 masking
    wr(3'd4, 8'hE0);
    rd(3'd4, "R1 mask");
    // R3 no loopback
    wr(3'd4, 8'h0F);
    rd(3'd6, "R3 idle lines");
    // R2/R4 loopback all on
    wr(3'd4, 8'h1F);
    rd(3'd6, "R2 R4 all lines up");
    // R5 ring: rising did not set bit 2 (checked above); falling sets it
    wr(3'd4, 8'h1B);
    wr(3'd4, 8'h1B);
    rd(3'd6, "R5 ring fall R6 sticky");
    rd(3'd6, "R6 cleared after read");
    // R7 writes to status/line status ignored
    wr(3'd6, 8'hFF);
    wr(3'd5, 8'hFF);
    rd(3'd6, "R7 status unchanged");
    rd(3'd4, "R7 ctl unchanged");
    // R11 scratch
    wr(3'd7, 8'h3C);
    rd(3'd7, "R11 scratch");
    // R12 hold
    held = rdata;
    repeat (3) @(negedge clk);
    check("R12 hold", rdata, held);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd3) d[7] = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 0) wr(a, d);
      else rd(a, req_of(a));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule